// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a real address by reading a chain of 64-bit translation-table entries from memory, one read at a time, over a plain request/response read port. The address-space mode picks one of three table descriptors: primary, secondary or home. A two-bit type field in that descriptor sets the table level where the walk begins, so a walk takes two to five reads. A descriptor can also declare a real space, in which case no memory is read. The walker reports the real page address, read/write/execute permissions, a fault code and a 64-bit exception word, all together with a one-cycle done pulse.

After a successful translation, a real address in the low 8 KiB window is moved by adding the prefix value. If the final address is within memory size, one key-update strobe marks the page as referenced and, when write permission remains, as changed. When translation is switched off, the page address passes through unchanged, after an optional 31-bit mask. The descriptor, prefix and memory-size inputs must stay stable while a walk is in progress.

Top module: `xw_top`

## Requirements
- R1: After reset, busy, done, mem_req and key_we are low and fault is 0.
- R2: The mode input picks the descriptor: 1 picks desc_pri, 2 picks desc_sec, 3 picks desc_home, and 0 is treated as 1. The effective space code (1, 2 or 3) is ORed into bits [1:0] of every exception word.
- R3: Descriptor bits [3:2] give the start type: 3 means five reads, 2 means four, 1 means three and 0 means two. A region read at step s (0..3) goes to (entry & ~0xFFF) + ((va >> (50-11s)) & 0x3FF8). The final (page-table) read goes to (entry & ~0x7FF) + ((va >> 9) & 0x7F8). Here entry is the descriptor or the previously read entry.
- R4: Before any read, type 2 with any of va[63:53] set, type 1 with any of va[63:42] set, or type 0 with any of va[63:31] set ends with fault 1 (specification).
- R5: Bit 5 set in the descriptor or in any region or segment entry ends with fault 2. Bit 10 set in the page entry ends with fault 3. On any fault, real_addr and all permissions are 0 and key_we stays low.
- R6: A descriptor with bit 6 set (and bit 5 clear) maps the address directly with no memory read.
- R7: Bit 9 in the page entry removes write permission. A write (kind 1) to such a page ends with fault 4, and the exception word is the page address | space | 4.
- R8: With dat_en low, real_addr equals the page address (low 12 bits cleared) with all three permissions set. With wide_addr low, the address is first masked to 0x7FFFFFFF.
- R9: In mode 2, a fetch (kind 2) walks with desc_pri and keeps only execute permission. Other accesses walk with desc_sec and lose execute permission.
- R10: A successful real address below 0x2000 has prefix added to it.
- R11: On success with final address <= mem_size, key_we pulses with done; key_page is address >> 12, key_ref is the read permission and key_chg is the write permission.
- R12: mem_req is a one-cycle pulse, with at most one read outstanding; busy is high from accept through done; done is a one-cycle pulse. Fault codes: 0 none, 1 specification, 2 segment, 3 page, 4 protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a translation (taken when idle) |
| va | input | 64 | Virtual address |
| kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mode | input | 2 | Address-space mode |
| dat_en | input | 1 | Translation enabled |
| wide_addr | input | 1 | 64-bit addressing; low selects 31-bit mask |
| desc_pri | input | 64 | Primary table descriptor |
| desc_sec | input | 64 | Secondary table descriptor |
| desc_home | input | 64 | Home table descriptor |
| prefix | input | 64 | Low-window relocation value |
| mem_size | input | 64 | Highest address that has storage keys |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| real_addr | output | 64 | Translated real address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| fault | output | 3 | Fault code |
| exc_word | output | 64 | Exception word |
| key_we | output | 1 | Storage-key update strobe |
| key_page | output | 52 | Page number to update |
| key_ref | output | 1 | Set reference bit |
| key_chg | output | 1 | Set change bit |

## Verification
The hardest cases to reach are a fault deep in a five-level walk and the secondary-mode fetch. The deep fault needs a chain of valid entries at addresses derived from the virtual address, with one entry carrying the invalid bit. The fetch case needs the walk to ignore the secondary descriptor. The bench builds each table chain in a sparse memory model from the same address formula, and poisons the descriptor that must not be used with the invalid bit, so a wrong choice shows up as a fault. Response latency is varied so that the single-outstanding-read rule is exercised.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W  = 64;
    localparam int PG_SH = 12;
    localparam int KEY_W = VA_W - PG_SH;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [2:0] FLT_NONE = 3'd0;
    localparam logic [2:0] FLT_SPEC = 3'd1;
    localparam logic [2:0] FLT_SEG  = 3'd2;
    localparam logic [2:0] FLT_PAGE = 3'd3;
    localparam logic [2:0] FLT_PROT = 3'd4;

    localparam int BIT_INV    = 5;
    localparam int BIT_REAL   = 6;
    localparam int BIT_RO     = 9;
    localparam int BIT_PG_INV = 10;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PREP = 3'd1,
        S_RD   = 3'd2,
        S_WT   = 3'd3,
        S_DONE = 3'd4
    } xw_state_e;

    typedef struct packed {
        xw_state_e          state;
        logic [VA_W-1:0]    va;
        logic [1:0]         kind;
        logic [1:0]         space;
        logic               sec_fetch;
        logic               sec_data;
        logic               dat;
        logic [VA_W-1:0]    cur;
        logic [2:0]         step;
        logic [VA_W-1:0]    real_a;
        logic               pr;
        logic               pw;
        logic               px;
        logic [2:0]         fault;
        logic [VA_W-1:0]    exc;
        logic               key_we;
        logic [KEY_W-1:0]   key_page;
        logic               key_ref;
        logic               key_chg;
    } xw_regs_t;
endpackage

// File: rtl/xw_range.sv
module xw_range
    import xw_pkg::*;
#(
    parameter int NUM_LEVELS = 5
) (
    input  logic [32:0] va_top,
    input  logic [1:0]  ttype,
    output logic        spec_err,
    output logic [2:0]  first_step
);
    localparam int LAST = NUM_LEVELS - 1;

    always_comb begin
        unique case (ttype)
            2'd3:    spec_err = 1'b0;
            2'd2:    spec_err = |va_top[32:22];
            2'd1:    spec_err = |va_top[32:11];
            default: spec_err = |va_top;
        endcase
        first_step = 3'(LAST - 1) - {1'b0, ttype};
    end
endmodule

// File: rtl/xw_index.sv
module xw_index
    import xw_pkg::*;
#(
    parameter int NUM_LEVELS = 5
) (
    input  logic [51:0]      va_hi,
    input  logic [52:0]      entry_hi,
    input  logic [2:0]       step,
    output logic [VA_W-1:0]  rd_addr
);
    localparam int LAST = NUM_LEVELS - 1;

    logic [VA_W-1:0] cand [NUM_LEVELS];

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        if (g == LAST) begin : g_seg
            assign cand[g] = {entry_hi, 11'b0} + {53'b0, va_hi[7:0], 3'b0};
        end else begin : g_reg
            localparam int LO = 41 - 11 * g;
            assign cand[g] = {entry_hi[52:1], 12'b0} + {50'b0, va_hi[LO+10:LO], 3'b0};
        end
    end

    always_comb begin
        rd_addr = cand[LAST];
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (step == 3'(i)) rd_addr = cand[i];
        end
    end
endmodule

// File: rtl/xw_final.sv
module xw_final
    import xw_pkg::*;
#(
    parameter logic [VA_W-1:0] LOW_LIMIT = 64'h2000
) (
    input  logic [VA_W-1:0]  raw_a,
    input  logic [VA_W-1:0]  prefix,
    input  logic [VA_W-1:0]  mem_size,
    output logic [VA_W-1:0]  reloc_a,
    output logic             in_mem,
    output logic [KEY_W-1:0] page
);
    always_comb begin
        reloc_a = (raw_a < LOW_LIMIT) ? raw_a + prefix : raw_a;
        in_mem  = (reloc_a <= mem_size);
        page    = reloc_a[VA_W-1:PG_SH];
    end
endmodule

// File: rtl/xw_top.sv
module xw_top
    import xw_pkg::*;
#(
    parameter int              NUM_LEVELS = 5,
    parameter logic [VA_W-1:0] LOW_LIMIT  = 64'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       va,
    input  logic [1:0]        kind,
    input  logic [1:0]        mode,
    input  logic              dat_en,
    input  logic              wide_addr,
    input  logic [63:0]       desc_pri,
    input  logic [63:0]       desc_sec,
    input  logic [63:0]       desc_home,
    input  logic [63:0]       prefix,
    input  logic [63:0]       mem_size,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [63:0]       real_addr,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic [2:0]        fault,
    output logic [63:0]       exc_word,
    output logic              key_we,
    output logic [51:0]       key_page,
    output logic              key_ref,
    output logic              key_chg
);
    localparam int LAST = NUM_LEVELS - 1;
    localparam logic [VA_W-1:0] PG_MASK = ~((64'd1 << PG_SH) - 64'd1);

    xw_regs_t q, w_d, d;

    logic [VA_W-1:0] desc;
    logic            spec_err;
    logic [2:0]      first_step;
    logic [VA_W-1:0] idx_addr;
    logic [VA_W-1:0] reloc_a;
    logic            in_mem;
    logic [KEY_W-1:0] page;

    logic            fin_go;
    logic [2:0]      f_fault;
    logic [VA_W-1:0] f_real;
    logic            f_ro;

    always_comb begin
        unique case (q.space)
            2'd2:    desc = desc_sec;
            2'd3:    desc = desc_home;
            default: desc = desc_pri;
        endcase
    end

    xw_range #(.NUM_LEVELS(NUM_LEVELS)) u_range (
        .va_top     (q.va[63:31]),
        .ttype      (desc[3:2]),
        .spec_err   (spec_err),
        .first_step (first_step)
    );

    xw_index #(.NUM_LEVELS(NUM_LEVELS)) u_index (
        .va_hi    (q.va[63:12]),
        .entry_hi (q.cur[63:11]),
        .step     (q.step),
        .rd_addr  (idx_addr)
    );

    xw_final #(.LOW_LIMIT(LOW_LIMIT)) u_final (
        .raw_a    (f_real),
        .prefix   (prefix),
        .mem_size (mem_size),
        .reloc_a  (reloc_a),
        .in_mem   (in_mem),
        .page     (page)
    );

    // walk sequencing
    always_comb begin
        logic [VA_W-1:0] va_m;
        logic [1:0]      sp;
        w_d     = q;
        w_d.key_we = 1'b0;
        fin_go  = 1'b0;
        f_fault = FLT_NONE;
        f_real  = q.va;
        f_ro    = 1'b0;
        va_m    = wide_addr ? va : (va & 64'h7fff_ffff);
        sp      = (mode == 2'd0) ? 2'd1 : mode;
        if (mode == 2'd2 && kind == ACC_FETCH) sp = 2'd1;

        unique case (q.state)
            S_IDLE: begin
                if (start) begin
                    w_d.state     = S_PREP;
                    w_d.va        = va_m & PG_MASK;
                    w_d.kind      = kind;
                    w_d.space     = sp;
                    w_d.dat       = dat_en;
                    w_d.sec_fetch = dat_en && mode == 2'd2 && kind == ACC_FETCH;
                    w_d.sec_data  = dat_en && mode == 2'd2 && kind != ACC_FETCH;
                end
            end
            S_PREP: begin
                if (!q.dat) begin
                    fin_go = 1'b1;
                end else if (spec_err) begin
                    fin_go  = 1'b1;
                    f_fault = FLT_SPEC;
                end else if (desc[BIT_INV]) begin
                    fin_go  = 1'b1;
                    f_fault = FLT_SEG;
                end else if (desc[BIT_REAL]) begin
                    fin_go = 1'b1;
                end else begin
                    w_d.cur   = desc;
                    w_d.step  = first_step;
                    w_d.state = S_RD;
                end
            end
            S_RD: begin
                w_d.state = S_WT;
            end
            S_WT: begin
                if (mem_rvalid) begin
                    if (q.step != 3'(LAST)) begin
                        if (mem_rdata[BIT_INV]) begin
                            fin_go  = 1'b1;
                            f_fault = FLT_SEG;
                        end else begin
                            w_d.cur   = mem_rdata;
                            w_d.step  = q.step + 3'd1;
                            w_d.state = S_RD;
                        end
                    end else if (mem_rdata[BIT_PG_INV]) begin
                        fin_go  = 1'b1;
                        f_fault = FLT_PAGE;
                    end else begin
                        fin_go = 1'b1;
                        f_real = mem_rdata & PG_MASK;
                        f_ro   = mem_rdata[BIT_RO];
                    end
                end
            end
            S_DONE: begin
                w_d.state = S_IDLE;
            end
            default: begin
                w_d.state = S_IDLE;
            end
        endcase
    end

    // result formation
    always_comb begin
        logic [2:0] flt;
        logic       r, w, x;
        d   = w_d;
        flt = f_fault;
        if (flt == FLT_NONE && q.kind == ACC_WRITE && f_ro) flt = FLT_PROT;
        r = 1'b1;
        w = !f_ro;
        x = 1'b1;
        if (q.sec_fetch) begin
            r = 1'b0;
            w = 1'b0;
        end
        if (q.sec_data) x = 1'b0;
        if (fin_go) begin
            d.state = S_DONE;
            d.fault = flt;
            if (flt != FLT_NONE) begin
                d.real_a = '0;
                d.pr     = 1'b0;
                d.pw     = 1'b0;
                d.px     = 1'b0;
                d.exc    = q.va | {61'b0, flt == FLT_PROT, q.space};
                d.key_we = 1'b0;
            end else begin
                d.real_a   = reloc_a;
                d.pr       = r;
                d.pw       = w;
                d.px       = x;
                d.exc      = '0;
                d.key_we   = in_mem;
                d.key_page = page;
                d.key_ref  = r;
                d.key_chg  = w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = (q.state == S_RD);
    assign mem_addr  = idx_addr;
    assign busy      = (q.state != S_IDLE);
    assign done      = (q.state == S_DONE);
    assign real_addr = q.real_a;
    assign perm_r    = q.pr;
    assign perm_w    = q.pw;
    assign perm_x    = q.px;
    assign fault     = q.fault;
    assign exc_word  = q.exc;
    assign key_we    = q.key_we;
    assign key_page  = q.key_page;
    assign key_ref   = q.key_ref;
    assign key_chg   = q.key_chg;
endmodule

// File: rtl/xw_chk.sv
module xw_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        busy,
    input logic        done,
    input logic [2:0]  fault,
    input logic [63:0] exc_word,
    input logic [63:0] real_addr,
    input logic        perm_r,
    input logic        perm_w,
    input logic        perm_x,
    input logic        key_we
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (mem_req)    pend_q <= 1'b1;
        else if (mem_rvalid) pend_q <= 1'b0;
    end

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend_q);

    // R12
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    key_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we |-> (done && fault == 3'd0));

    // R5
    fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (!perm_r && !perm_w && !perm_x && real_addr == 64'd0));

    // R7
    prot_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == 3'd4) |-> (exc_word[2] && exc_word[1:0] != 2'd0));

    // R9
    write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && perm_w) |-> perm_r);
endmodule

bind xw_top xw_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .exc_word   (exc_word),
    .real_addr  (real_addr),
    .perm_r     (perm_r),
    .perm_w     (perm_w),
    .perm_x     (perm_x),
    .key_we     (key_we)
);

// File: tb/tb_xw_top.sv
`timescale 1ns/1ps
module tb_xw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va = '0;
    logic [1:0]  kind = '0;
    logic [1:0]  mode = 2'd1;
    logic        dat_en = 1'b1;
    logic        wide_addr = 1'b1;
    logic [63:0] desc_pri = '0, desc_sec = '0, desc_home = '0;
    logic [63:0] prefix = 64'h0050_0000;
    logic [63:0] mem_size = 64'h1000_0000;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        busy, done, perm_r, perm_w, perm_x, key_we, key_ref, key_chg;
    logic [63:0] real_addr, exc_word;
    logic [2:0]  fault;
    logic [51:0] key_page;

    xw_top dut (.*);

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    logic [63:0] e_ra, e_exc;
    logic [2:0]  e_perm, e_fault;
    logic        e_kwe, e_kref, e_kchg;
    logic [51:0] e_kpage;
    string       e_tag;
    bit          got_done = 0;
    bit          live = 0;
    int          lat = 1;

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic logic [63:0] rd(logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] idx(logic [63:0] e, int lvl, logic [63:0] v);
        if (lvl == 4) return (e & ~64'h7ff) + ((v >> 9) & 64'h7f8);
        return (e & ~64'hfff) + ((v >> (50 - 11 * lvl)) & 64'h3ff8);
    endfunction

    function automatic logic [63:0] dsc(int t);
        return 64'h0008_0000 | (64'(t) << 2);
    endfunction

    task automatic chain(logic [63:0] d, logic [63:0] v, logic [63:0] pte, int bad);
        logic [63:0] e = d;
        logic [63:0] n;
        for (int lvl = 3 - int'(d[3:2]); lvl <= 4; lvl++) begin
            if (lvl < 4) n = 64'h10_0000 + 64'(lvl + 1) * 64'h1_0000 + ((lvl == bad) ? 64'h20 : 64'h0);
            else n = pte;
            mem[idx(e, lvl, v)] = n;
            e = n;
        end
    endtask

    task automatic build_exp(logic [63:0] va_i, logic [1:0] k, logic [1:0] m, bit dat, bit a64);
        logic [63:0] v, d, e, n, a, ra, lim;
        int sp, f, lvl;
        bit r, w, x, ro, sf, sd;
        v = a64 ? va_i : (va_i & 64'h7fff_ffff);
        v = v & ~64'hfff;
        ra = v; r = 1; w = 1; x = 1; f = 0; ro = 0; sf = 0; sd = 0;
        sp = (m == 0) ? 1 : int'(m);
        exp_q.delete();
        if (dat) begin
            if (m == 2) begin
                if (k == 2) begin sp = 1; sf = 1; end
                else sd = 1;
            end
            d = (sp == 1) ? desc_pri : (sp == 2) ? desc_sec : desc_home;
            case (d[3:2])
                2'd3: lim = 64'h0;
                2'd2: lim = 64'hffe0_0000_0000_0000;
                2'd1: lim = 64'hffff_fc00_0000_0000;
                default: lim = 64'hffff_ffff_8000_0000;
            endcase
            if ((v & lim) != 0) f = 1;
            else if (d[5]) f = 2;
            else if (!d[6]) begin
                e = d;
                lvl = 3 - int'(d[3:2]);
                while (f == 0 && lvl <= 4) begin
                    a = idx(e, lvl, v);
                    exp_q.push_back(a);
                    n = rd(a);
                    if (lvl < 4) begin
                        if (n[5]) f = 2;
                    end else if (n[10]) f = 3;
                    else begin
                        ra = n & ~64'hfff;
                        ro = n[9];
                    end
                    e = n;
                    lvl++;
                end
            end
            if (ro) w = 0;
            if (f == 0 && k == 1 && ro) f = 4;
            if (f == 0 && sf) begin r = 0; w = 0; end
            if (f == 0 && sd) x = 0;
        end
        e_fault = 3'(f);
        e_kwe = 0; e_kpage = '0; e_kref = 0; e_kchg = 0;
        if (f != 0) begin
            e_ra = 0; e_perm = 3'b000;
            e_exc = v | 64'(sp) | ((f == 4) ? 64'd4 : 64'd0);
        end else begin
            if (ra < 64'h2000) ra = ra + prefix;
            e_ra = ra; e_perm = {r, w, x}; e_exc = 0;
            if (ra <= mem_size) begin
                e_kwe = 1; e_kpage = ra[63:12]; e_kref = r; e_kchg = w;
            end
        end
    endtask

    // memory responder
    int          cnt = 0;
    logic [63:0] raddr = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(raddr);
            end
        end
        if (mem_req) begin
            raddr = mem_addr;
            cnt   = lat;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live) begin
            if (mem_req) begin
                if (exp_q.size() == 0) chk(0, "R3 unexpected read", mem_addr, 64'd0);
                else begin
                    logic [63:0] a;
                    a = exp_q.pop_front();
                    chk(mem_addr == a, "R3 read address", mem_addr, a);
                end
            end
            if (done) begin
                got_done = 1;
                chk(real_addr == e_ra, {e_tag, " real"}, real_addr, e_ra);
                chk({perm_r, perm_w, perm_x} == e_perm, {e_tag, " perms"}, 64'({perm_r, perm_w, perm_x}), 64'(e_perm));
                chk(fault == e_fault, {e_tag, " fault"}, 64'(fault), 64'(e_fault));
                chk(exc_word == e_exc, {e_tag, " exc"}, exc_word, e_exc);
                chk(key_we == e_kwe, "R11 key strobe", 64'(key_we), 64'(e_kwe));
                if (e_kwe) chk({key_page, key_ref, key_chg} == {e_kpage, e_kref, e_kchg},
                               "R11 key fields", 64'({key_page, key_ref, key_chg}), 64'({e_kpage, e_kref, e_kchg}));
                chk(exp_q.size() == 0, "R3 read count", 64'(exp_q.size()), 64'd0);
            end else begin
                chk(key_we == 1'b0, "R11 strobe outside done", 64'(key_we), 64'd0);
            end
        end
    end

    task automatic run(string tag, logic [63:0] va_i, logic [1:0] k, logic [1:0] m, bit dat, bit a64);
        int n = 0;
        dat_en = dat; wide_addr = a64;
        build_exp(va_i, k, m, dat, a64);
        e_tag = tag;
        got_done = 0;
        @(negedge clk);
        va = va_i; kind = k; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R12 busy after accept", 64'(busy), 64'd1);
        while (!got_done && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!got_done) chk(0, {tag, " no done"}, 64'd0, 64'd1);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R12 idle after done", 64'({busy, done}), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    localparam logic [63:0] VA1 = 64'h0123_4567_89ab_c123;
    localparam logic [63:0] VA2 = 64'h001f_ffff_ffff_f000;
    localparam logic [63:0] VA3 = 64'h0000_0123_4567_8000;

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req == 0 && key_we == 0 && fault == 0,
            "R1 reset state", 64'({busy, done, mem_req, key_we, fault}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req == 0, "R1 idle after reset", 64'({busy, done, mem_req}), 64'd0);
        live = 1;

        // R3 five-level walk
        mem.delete(); desc_pri = dsc(3); chain(desc_pri, VA1 & ~64'hfff, 64'h0abc_d000, 9);
        run("R3 five reads", VA1, 2'd0, 2'd1, 1, 1);
        // R12 slow responses, write access
        lat = 4;
        run("R12 latency write", VA1, 2'd1, 2'd1, 1, 1);
        lat = 1;
        // R4 range checks
        desc_pri = dsc(2);
        run("R4 region-2 limit", VA1, 2'd0, 2'd1, 1, 1);
        mem.delete(); chain(desc_pri, VA2, 64'h0123_4000, 9);
        run("R3 four reads", VA2, 2'd0, 2'd1, 1, 1);
        desc_pri = dsc(1);
        run("R4 region-3 limit", 64'h0000_0400_0000_0000, 2'd0, 2'd1, 1, 1);
        desc_pri = dsc(0);
        run("R4 segment limit", 64'h0000_0000_8000_0000, 2'd0, 2'd1, 1, 1);
        // R10 segment walk ending in low window
        mem.delete(); chain(desc_pri, 64'h7fff_f000, 64'h0000_1000, 9);
        run("R10 prefix after walk", 64'h7fff_f000, 2'd0, 2'd1, 1, 1);
        // R6 real space
        desc_pri = dsc(3) | 64'h40;
        run("R6 real space", VA1, 2'd0, 2'd1, 1, 1);
        // R5 invalid entries
        mem.delete(); desc_pri = dsc(3); chain(desc_pri, VA1 & ~64'hfff, 64'h0abc_d000, 2);
        run("R5 invalid region entry", VA1, 2'd0, 2'd1, 1, 1);
        desc_pri = dsc(3) | 64'h20;
        run("R5 invalid descriptor", VA1, 2'd0, 2'd1, 1, 1);
        // R2 home space with invalid page entry
        mem.delete(); desc_pri = 64'h20; desc_home = dsc(1);
        chain(desc_home, VA3, 64'h0abc_0400, 9);
        run("R5 R2 home page fault", VA3, 2'd0, 2'd3, 1, 1);
        // R7 read-only page
        mem.delete(); desc_pri = dsc(0); chain(desc_pri, 64'h1234_5000, 64'h0200_0200, 9);
        run("R7 read-only read", 64'h1234_5678, 2'd0, 2'd1, 1, 0);
        run("R7 read-only write", 64'h1234_5678, 2'd1, 2'd1, 1, 0);
        // R9 secondary data and fetch
        mem.delete(); desc_pri = 64'h20; desc_sec = dsc(1); chain(desc_sec, VA3, 64'h0333_3000, 9);
        run("R9 secondary data", VA3, 2'd0, 2'd2, 1, 1);
        mem.delete(); desc_sec = 64'h20; desc_pri = dsc(0); chain(desc_pri, 64'h0004_2000, 64'h0444_4000, 9);
        run("R9 secondary fetch", 64'h0004_2abc, 2'd2, 2'd2, 1, 1);
        mem.delete(); chain(desc_pri, 64'h0004_2000, 64'h0444_4400, 9);
        run("R2 secondary fetch fault code", 64'h0004_2abc, 2'd2, 2'd2, 1, 1);
        mem.delete(); chain(desc_pri, 64'h0004_2000, 64'h0444_4000, 9);
        run("R2 mode zero", 64'h0004_2abc, 2'd0, 2'd0, 1, 1);
        // R8 translation off
        run("R8 pass-through", VA1, 2'd0, 2'd1, 0, 1);
        run("R8 31-bit mask", 64'hffff_ffff_8000_1abc, 2'd1, 2'd1, 0, 0);
        // R11 memory size boundary
        run("R11 at size", mem_size, 2'd0, 2'd1, 0, 1);
        run("R11 above size", mem_size + 64'h1000, 2'd0, 2'd1, 0, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule